// File: doc/BRIEF.md
# Dual-Edge Sigma-Delta Converter Core

This block is the digital half of a first-order sigma-delta analog-to-digital converter. A differential input pair acts as a 1-bit comparator between the analog input and the voltage on an external RC integrator. The core samples that comparator bit on both edges of its clock. It drives each sampled bit straight back out as the feedback level that charges or discharges the RC network, which closes the loop. Ones taken on rising edges and ones taken on falling edges are counted in two separate counters.

A conversion window lasts a fixed number of clock cycles, which is twice as many sample slots. When a window ends, the two counts are moved into the rising-edge domain and added. The sum saturates at the top code and is registered as the output word, and a one-cycle strobe marks the new result. The counters restart at once, so windows follow each other with no gap. With the default 128-cycle window, 256 samples make one 8-bit word. At a 27 MHz clock this gives a result about every 4.74 µs, half the window a single-edge modulator needs for the same resolution.

The result is a plain strobed output with no back-pressure. `eoc` is high for exactly one cycle, and `code_out` holds its value until the next strobe. A consumer that cannot take the word in that cycle reads it from `code_out` at any time before the next window ends.

Top module: `dsadc_dual_edge`

## Requirements
- R1: While `rst` is high at a rising edge, `code_out` reads 0 and `eoc` reads 0 after that edge; the reset is synchronous and active high.
- R2: A comparator bit sampled at a rising clock edge adds one to the result when it is 1. A window whose rising-edge samples are all 1 and whose falling-edge samples are all 0 gives the code 128.
- R3: A comparator bit sampled at a falling clock edge adds one to the result when it is 1. A window whose falling-edge samples are all 1 and whose rising-edge samples are all 0 gives the code 128.
- R4: `fb_out` equals the comparator bit taken at the most recent clock edge: the rising-edge sample while `clk` is high, and the falling-edge sample while `clk` is low.
- R5: The output code equals the number of ones among the 256 samples of a window (128 rising, 128 falling). Window n (n = 0, 1, ...) starts at the first rising edge with `rst` low plus 128·n cycles.
- R6: A count of 256 saturates to the code 255; smaller counts pass through unchanged.
- R7: `eoc` is high for one cycle at a time. It first rises after the 130th rising edge following reset release, then after every 128 further edges. It carries the result of the window that ended two edges earlier.
- R8: `code_out` changes only together with `eoc` and otherwise holds its value.
- R9: Each window counts from zero. A window of all ones followed at once by a window of all zeros gives 255 and then 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; both edges take a comparator sample |
| rst | input | 1 | Synchronous active-high reset, sampled on the rising edge |
| cmp_in | input | 1 | Comparator result: 1 when the analog input exceeds the integrator voltage |
| fb_out | output | 1 | Feedback level to the RC integrator, the most recent sample |
| code_out | output | 8 | Result of the last completed conversion window |
| eoc | output | 1 | One-cycle strobe marking a new `code_out` value |

## Verification
The bench builds the core with its default parameters: a 128-cycle window and an 8-bit word, so each window takes 256 samples. At that size every count from 0 to 256 can be reached, and the bench sweeps all of them through a behavioural integrator that reads `fb_out` back to choose the next comparator bit. This covers the saturation point, a count on a single edge only, back-to-back windows and a reset in the middle of a window. The strobe timing is checked on every cycle.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;
endpackage

// File: rtl/dsadc_window_timer.sv
module dsadc_window_timer #(
  parameter int WIN_CYCLES = 128
) (
  input  logic clk,
  input  logic rst,
  output logic rise_restart,
  output logic fall_restart,
  output logic win_done
);
  localparam int IDX_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_CYCLES - 1);

  logic [IDX_W-1:0] slot_q;
  logic             primed_q;
  logic             first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= '0;
      primed_q <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      slot_q   <= (slot_q == LAST_IDX) ? '0 : slot_q + 1'b1;
      primed_q <= 1'b1;
      first_q  <= (slot_q == '0);
    end
  end

  // slot_q is the index of the rising edge about to be taken
  assign rise_restart = (slot_q == '0);
  // first_q marks the half cycle that follows the window's first rising edge
  assign fall_restart = first_q;
  assign win_done     = (slot_q == '0) && primed_q;
endmodule

// File: rtl/dsadc_edge_counter.sv
module dsadc_edge_counter
  import dsadc_pkg::*;
#(
  parameter int    CNT_W = 8,
  parameter edge_e EDGE  = EDGE_RISE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] next_count;

  assign next_count = restart ? CNT_W'(bit_in) : count + CNT_W'(bit_in);

  generate
    if (EDGE == EDGE_RISE) begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= next_count;
      end
    end else begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) count <= '0;
        else     count <= next_count;
      end
    end
  endgenerate
endmodule

// File: rtl/dsadc_edge_sampler.sv
module dsadc_edge_sampler (
  input  logic clk,
  input  logic rst,
  input  logic cmp_in,
  output logic fb_out
);
  logic rise_bit_q;
  logic fall_bit_q;

  always_ff @(posedge clk) begin
    if (rst) rise_bit_q <= 1'b0;
    else     rise_bit_q <= cmp_in;
  end

  always_ff @(negedge clk) begin
    if (rst) fall_bit_q <= 1'b0;
    else     fall_bit_q <= cmp_in;
  end

  // the phase of clk tells which capture is the newer one
  assign fb_out = clk ? rise_bit_q : fall_bit_q;
endmodule

// File: rtl/dsadc_dual_edge.sv
module dsadc_dual_edge
  import dsadc_pkg::*;
#(
  parameter int WIN_CYCLES = 128,
  parameter int OUT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_in,
  output logic             fb_out,
  output logic [OUT_W-1:0] code_out,
  output logic             eoc
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam int SUM_W = CNT_W + 1;
  localparam int CODE_MAX = (1 << OUT_W) - 1;

  logic             rise_restart;
  logic             fall_restart;
  logic             win_done;
  logic [CNT_W-1:0] rise_cnt;
  logic [CNT_W-1:0] fall_cnt;
  logic [CNT_W-1:0] rise_hold_q;
  logic [CNT_W-1:0] fall_hold_q;
  logic             load_q;
  logic [SUM_W-1:0] sum;
  logic [OUT_W-1:0] code_next;

  dsadc_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .rise_restart (rise_restart),
    .fall_restart (fall_restart),
    .win_done     (win_done)
  );

  dsadc_edge_sampler u_sampler (
    .clk    (clk),
    .rst    (rst),
    .cmp_in (cmp_in),
    .fb_out (fb_out)
  );

  dsadc_edge_counter #(.CNT_W(CNT_W), .EDGE(EDGE_RISE)) u_rise_cnt (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (cmp_in),
    .restart (rise_restart),
    .count   (rise_cnt)
  );

  dsadc_edge_counter #(.CNT_W(CNT_W), .EDGE(EDGE_FALL)) u_fall_cnt (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (cmp_in),
    .restart (fall_restart),
    .count   (fall_cnt)
  );

  assign sum = SUM_W'(rise_hold_q) + SUM_W'(fall_hold_q);

  generate
    if (SUM_W > OUT_W) begin : g_sat
      assign code_next = (sum > SUM_W'(CODE_MAX)) ? OUT_W'(CODE_MAX) : sum[OUT_W-1:0];
    end else begin : g_nosat
      assign code_next = OUT_W'(sum);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_hold_q <= '0;
      fall_hold_q <= '0;
      load_q      <= 1'b0;
      code_out    <= '0;
      eoc         <= 1'b0;
    end else begin
      load_q <= win_done;
      eoc    <= load_q;
      if (win_done) begin
        rise_hold_q <= rise_cnt;
        fall_hold_q <= fall_cnt;
      end
      if (load_q) code_out <= code_next;
    end
  end
endmodule

// File: rtl/dsadc_dual_edge_chk.sv
module dsadc_dual_edge_chk #(
  parameter int WIN_CYCLES = 128,
  parameter int OUT_W      = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [OUT_W-1:0] code_out,
  input logic             eoc
);
  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (eoc) begin
      gap_q  <= 32'd1;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 32'd1;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!eoc && code_out == '0));

  assert_eoc_single_R7: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc);

  assert_eoc_period_R7: assert property (@(posedge clk) disable iff (rst)
    (eoc && seen_q) |-> (gap_q == 32'(WIN_CYCLES)));

  assert_code_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !eoc |=> (eoc || $stable(code_out)));
endmodule

bind dsadc_dual_edge dsadc_dual_edge_chk #(
  .WIN_CYCLES (WIN_CYCLES),
  .OUT_W      (OUT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .code_out (code_out),
  .eoc      (eoc)
);

// File: tb/dsadc_dual_edge_test.sv
`timescale 1ns/1ps
module dsadc_dual_edge_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_in = 1'b0;
  logic       fb_out;
  logic [7:0] code_out;
  logic       eoc;

  int    checks = 0;
  int    fails = 0;
  int    exp_q[$];
  string tag_q[$];
  int    n_edges = 0;

  dsadc_dual_edge uut (
    .clk      (clk),
    .rst      (rst),
    .cmp_in   (cmp_in),
    .fb_out   (fb_out),
    .code_out (code_out),
    .eoc      (eoc)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one sample slot; leaves time just after the edge
  task automatic half(input bit b, input bit on_rise);
    cmp_in = b;
    if (on_rise) @(posedge clk);
    else         @(negedge clk);
    #2;
    chk(fb_out == b, "R4 fb_out", int'(fb_out), int'(b));
  endtask

  // mode 0: integrator loop with target x; 1: rise-only ones; 2: fall-only ones;
  // 3: all ones; 4: all zeros
  task automatic run_win(input int mode, input int x, input string tag);
    int ones = 0;
    int acc = 0;
    for (int i = 0; i < 256; i++) begin
      bit b;
      case (mode)
        0: b = (acc + x >= 256);
        1: b = (i % 2 == 0);
        2: b = (i % 2 == 1);
        3: b = 1'b1;
        default: b = 1'b0;
      endcase
      half(b, i % 2 == 0);
      if (mode == 0) acc = acc + x - (fb_out ? 256 : 0);
      ones += int'(b);
    end
    exp_q.push_back(ones > 255 ? 255 : ones);
    tag_q.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk); #3; rst = 1'b1; cmp_in = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    tag_q.delete();
    #3; rst = 1'b0;
  endtask

  // monitor: outputs change only on rising edges, sample after each falling edge
  always begin
    @(negedge clk); #1;
    if (rst) begin
      n_edges = 0;
      chk(code_out == 8'd0, "R1 code_out in reset", int'(code_out), 0);
      chk(eoc == 1'b0, "R1 eoc in reset", int'(eoc), 0);
    end else begin
      bit exp_eoc;
      n_edges++;
      exp_eoc = (n_edges >= 130) && ((n_edges - 130) % 128 == 0);
      chk(eoc == exp_eoc, "R7 eoc timing", int'(eoc), int'(exp_eoc));
      if (eoc && exp_q.size() > 0) begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(code_out) == e, t, int'(code_out), e);
      end
    end
  end

  initial begin
    #(8 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #3; rst = 1'b0;
    // directed windows back to back
    run_win(1, 0, "R2 rising-only ones");
    run_win(2, 0, "R3 falling-only ones");
    run_win(3, 0, "R6 saturation of 256");
    run_win(4, 0, "R9 clear after full window");
    run_win(0, 255, "R6 count 255 passes");
    // reset in the middle of a window
    for (int i = 0; i < 60; i++) half(1'b1, i % 2 == 0);
    do_reset();
    run_win(0, 77, "R1 restart after mid-window reset");
    // full sweep of all counts through the loop model
    for (int x = 0; x <= 256; x++) run_win(0, x, "R5 sweep count");
    cmp_in = 1'b0;
    repeat (4) @(negedge clk);
    #3;
    chk(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule